// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a parallel NOR-style flash memory. It watches every host bus write, reads the low byte of the data as a command code, and walks through one-cycle or two-cycle command sequences. Depending on the last command, later host reads return array contents, a manufacturer or device signature, or an 8-bit status byte. A second write after a program opcode, or a confirm after an erase opcode, produces a one-cycle start pulse towards an external program/erase engine, together with the captured address, data or block number.

While the engine is working, the block ignores almost everything the host writes. It lets the host ask for status, and it lets the host ask to suspend a running erase. The block holds that suspend request until the host resumes it or the engine finishes. It keeps three sticky error flags in the status byte, sets them from the engine's completion report or from a malformed erase sequence, and clears them on command. The engine is modelled only by its completion pulse, its two failure qualifiers and a level that says it has parked the erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, reads return array data. The status byte is 80h, which is ready with no flags set. No start pulse is active and suspend_req is low.
- R2: A write with low byte FFh selects array reads, so rd_data equals array_rdata. 90h selects signature reads: rd_addr of zero returns MFR_ID and any other address returns DEV_ID. 70h selects status reads: rd_data is the status byte, zero-extended.
- R3: Code 50h clears status bits 5, 4 and 3, the erase, write and voltage error flags. It does not change the read selection and it consumes no second cycle.
- R4: Code 40h or 10h, followed by any write, raises prog_start for exactly one cycle after the second write. prog_addr and prog_data then hold that write's address and data, and reads switch to status.
- R5: Code 20h followed by a write of D0h raises erase_start for exactly one cycle. erase_blk then holds wr_addr bits above BLK_LSB, and reads switch to status.
- R6: Code 20h followed by any code other than D0h starts nothing. It sets status bits 5 and 4 and switches reads to status.
- R7: Status bit 7 (ready) is 0 from the start pulse until eng_done. While the engine is busy and not suspended, only 70h and B0h have any effect.
- R8: B0h while an erase runs raises suspend_req and selects status reads. Status bit 6 becomes 1 on the edge after eng_suspended is seen with the request pending, and ready then reads 1.
- R9: While an erase is suspended, only FFh, 90h, 70h, 50h and D0h are accepted. D0h drops suspend_req, clears bit 6, returns ready to 0 and selects status reads.
- R10: B0h has no effect when no erase is running. Read selection is unchanged and suspend_req stays low.
- R11: eng_done ends the operation and ready returns to 1. With eng_fail it sets bit 5 after an erase or bit 4 after a program. With eng_vlow it sets bit 3.
- R12: With no sequence pending and the engine idle, a first-cycle code outside the set FFh, 90h, 70h, 50h, 40h, 10h, 20h has no effect.
- R13: prog_start and erase_start are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write cycle strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data; bits 7:0 carry the command code |
| rd_addr | input | ADDR_W | Host read address |
| array_rdata | input | DATA_W | Data from the memory array for rd_addr |
| rd_data | output | DATA_W | Read data selected by the current read selection |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_fail | input | 1 | Qualifies eng_done: operation failed |
| eng_vlow | input | 1 | Qualifies eng_done: programming voltage was low |
| eng_suspended | input | 1 | Engine has parked the erase |
| prog_start | output | 1 | One-cycle program start pulse |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |
| erase_start | output | 1 | One-cycle erase start pulse |
| erase_blk | output | ADDR_W-BLK_LSB | Block number to erase |
| suspend_req | output | 1 | Erase suspend request level |

## Verification
The bench builds the block with a 10-bit address and BLK_LSB of 7, so the array holds eight blocks. A block boundary can then be reached with a short address. Sixteen-bit data keeps upper bits present that the command decode must ignore. The signature codes are chosen to differ from every array word the bench presents, so a wrong read selection shows up on rd_data at once. The narrow address lets the erase-block extraction and the zero/non-zero signature split be reached directly.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WDATA = 2'd1,
    SQ_ECONF = 2'd2
  } seq_state_e;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_READ_SR    = 8'h70;
  localparam logic [7:0] OP_CLEAR_SR   = 8'h50;
  localparam logic [7:0] OP_WRITE_A    = 8'h40;
  localparam logic [7:0] OP_WRITE_B    = 8'h10;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_SUSPEND    = 8'hB0;

  // error flag vector layout, mapped onto status bits 5..3
  localparam int ERR_V = 0;
  localparam int ERR_W = 1;
  localparam int ERR_E = 2;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      op_busy,
  input  logic                      held,
  input  logic                      erase_run,
  output rd_mode_e                  mode,
  output logic                      go_write,
  output logic                      go_erase,
  output logic                      seq_err,
  output logic                      clr_err,
  output logic                      susp_cmd,
  output logic                      resume_cmd,
  output logic                      prog_start,
  output logic                      erase_start,
  output logic [ADDR_W-1:0]         prog_addr,
  output logic [DATA_W-1:0]         prog_data,
  output logic [ADDR_W-BLK_LSB-1:0] erase_blk
);

  localparam int BLK_W = ADDR_W - BLK_LSB;

  seq_state_e state_q, state_n;
  rd_mode_e   mode_q, mode_n;
  logic [7:0] cmd;
  logic       prog_start_q, erase_start_q;
  logic [ADDR_W-1:0] prog_addr_q;
  logic [DATA_W-1:0] prog_data_q;
  logic [BLK_W-1:0]  erase_blk_q;

  assign cmd = wr_data[7:0];

  always_comb begin
    state_n    = state_q;
    mode_n     = mode_q;
    go_write   = 1'b0;
    go_erase   = 1'b0;
    seq_err    = 1'b0;
    clr_err    = 1'b0;
    susp_cmd   = 1'b0;
    resume_cmd = 1'b0;
    if (wr_en) begin
      unique case (state_q)
        SQ_WDATA: begin
          go_write = 1'b1;
          mode_n   = RD_STATUS;
          state_n  = SQ_IDLE;
        end
        SQ_ECONF: begin
          if (cmd == OP_CONFIRM) go_erase = 1'b1;
          else                   seq_err  = 1'b1;
          mode_n  = RD_STATUS;
          state_n = SQ_IDLE;
        end
        default: begin
          state_n = SQ_IDLE;
          if (op_busy) begin
            if (cmd == OP_READ_SR) begin
              mode_n = RD_STATUS;
            end else if (cmd == OP_SUSPEND && erase_run) begin
              susp_cmd = 1'b1;
              mode_n   = RD_STATUS;
            end
          end else if (held) begin
            unique case (cmd)
              OP_READ_ARRAY: mode_n = RD_ARRAY;
              OP_READ_ID:    mode_n = RD_IDENT;
              OP_READ_SR:    mode_n = RD_STATUS;
              OP_CLEAR_SR:   clr_err = 1'b1;
              OP_CONFIRM: begin
                resume_cmd = 1'b1;
                mode_n     = RD_STATUS;
              end
              default: ;
            endcase
          end else begin
            unique case (cmd)
              OP_READ_ARRAY: mode_n  = RD_ARRAY;
              OP_READ_ID:    mode_n  = RD_IDENT;
              OP_READ_SR:    mode_n  = RD_STATUS;
              OP_CLEAR_SR:   clr_err = 1'b1;
              OP_WRITE_A:    state_n = SQ_WDATA;
              OP_WRITE_B:    state_n = SQ_WDATA;
              OP_ERASE:      state_n = SQ_ECONF;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= SQ_IDLE;
      mode_q        <= RD_ARRAY;
      prog_start_q  <= 1'b0;
      erase_start_q <= 1'b0;
    end else begin
      state_q       <= state_n;
      mode_q        <= mode_n;
      prog_start_q  <= go_write;
      erase_start_q <= go_erase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr_q <= '0;
      prog_data_q <= '0;
    end else if (go_write) begin
      prog_addr_q <= wr_addr;
      prog_data_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_blk_q <= '0;
    end else if (go_erase) begin
      erase_blk_q <= wr_addr[ADDR_W-1:BLK_LSB];
    end
  end

  assign mode        = mode_q;
  assign prog_start  = prog_start_q;
  assign erase_start = erase_start_q;
  assign prog_addr   = prog_addr_q;
  assign prog_data   = prog_data_q;
  assign erase_blk   = erase_blk_q;

endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_write,
  input  logic       go_erase,
  input  logic       seq_err,
  input  logic       clr_err,
  input  logic       susp_cmd,
  input  logic       resume_cmd,
  input  logic       eng_done,
  input  logic       eng_fail,
  input  logic       eng_vlow,
  input  logic       eng_suspended,
  output logic [7:0] status,
  output logic       op_busy,
  output logic       held,
  output logic       erase_run,
  output logic       suspend_req
);

  logic       active_q, active_n;
  logic       is_erase_q, is_erase_n;
  logic       sreq_q, sreq_n;
  logic       susp_q, susp_n;
  logic [2:0] err_q, err_n;
  logic       finish;

  assign finish = eng_done & active_q;

  always_comb begin
    active_n   = active_q;
    is_erase_n = is_erase_q;
    sreq_n     = sreq_q;
    susp_n     = susp_q;
    err_n      = clr_err ? 3'b000 : err_q;

    if (go_write || go_erase) begin
      active_n   = 1'b1;
      is_erase_n = go_erase;
    end
    if (susp_cmd) sreq_n = 1'b1;
    if (resume_cmd) begin
      sreq_n = 1'b0;
      susp_n = 1'b0;
    end else if (sreq_q && eng_suspended) begin
      susp_n = 1'b1;
    end
    if (seq_err) begin
      err_n[ERR_E] = 1'b1;
      err_n[ERR_W] = 1'b1;
    end
    if (finish) begin
      active_n = 1'b0;
      sreq_n   = 1'b0;
      susp_n   = 1'b0;
      if (eng_fail) begin
        if (is_erase_q) err_n[ERR_E] = 1'b1;
        else            err_n[ERR_W] = 1'b1;
      end
      if (eng_vlow) err_n[ERR_V] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      is_erase_q <= 1'b0;
      sreq_q     <= 1'b0;
      susp_q     <= 1'b0;
      err_q      <= 3'b000;
    end else begin
      active_q   <= active_n;
      is_erase_q <= is_erase_n;
      sreq_q     <= sreq_n;
      susp_q     <= susp_n;
      err_q      <= err_n;
    end
  end

  assign status      = {(~active_q | susp_q), susp_q, err_q, 3'b000};
  assign op_busy     = active_q & ~susp_q;
  assign held        = susp_q;
  assign erase_run   = active_q & is_erase_q;
  assign suspend_req = sreq_q;

endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
  import fcd_pkg::*;
#(
  parameter int          ADDR_W = 18,
  parameter int          DATA_W = 16,
  parameter logic [15:0] MFR_ID = 16'h005A,
  parameter logic [15:0] DEV_ID = 16'h00C3
) (
  input  rd_mode_e          mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic [7:0]        status,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - 8;

  logic [DATA_W-1:0] ident_word;

  assign ident_word = (rd_addr == '0) ? DATA_W'(MFR_ID) : DATA_W'(DEV_ID);

  always_comb begin
    unique case (mode)
      RD_IDENT:  rd_data = ident_word;
      RD_STATUS: rd_data = {{PAD_W{1'b0}}, status};
      default:   rd_data = array_rdata;
    endcase
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int          ADDR_W  = 18,
  parameter int          DATA_W  = 16,
  parameter int          BLK_LSB = 14,
  parameter logic [15:0] MFR_ID  = 16'h005A,
  parameter logic [15:0] DEV_ID  = 16'h00C3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [DATA_W-1:0]         array_rdata,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      eng_done,
  input  logic                      eng_fail,
  input  logic                      eng_vlow,
  input  logic                      eng_suspended,
  output logic                      prog_start,
  output logic [ADDR_W-1:0]         prog_addr,
  output logic [DATA_W-1:0]         prog_data,
  output logic                      erase_start,
  output logic [ADDR_W-BLK_LSB-1:0] erase_blk,
  output logic                      suspend_req
);

  rd_mode_e   mode_w;
  logic       go_write_w, go_erase_w, seq_err_w, clr_err_w;
  logic       susp_cmd_w, resume_cmd_w;
  logic       op_busy_w, held_w, erase_run_w;
  logic [7:0] sr_w;

  fcd_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BLK_LSB(BLK_LSB)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .op_busy    (op_busy_w),
    .held       (held_w),
    .erase_run  (erase_run_w),
    .mode       (mode_w),
    .go_write   (go_write_w),
    .go_erase   (go_erase_w),
    .seq_err    (seq_err_w),
    .clr_err    (clr_err_w),
    .susp_cmd   (susp_cmd_w),
    .resume_cmd (resume_cmd_w),
    .prog_start (prog_start),
    .erase_start(erase_start),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .erase_blk  (erase_blk)
  );

  fcd_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_write     (go_write_w),
    .go_erase     (go_erase_w),
    .seq_err      (seq_err_w),
    .clr_err      (clr_err_w),
    .susp_cmd     (susp_cmd_w),
    .resume_cmd   (resume_cmd_w),
    .eng_done     (eng_done),
    .eng_fail     (eng_fail),
    .eng_vlow     (eng_vlow),
    .eng_suspended(eng_suspended),
    .status       (sr_w),
    .op_busy      (op_busy_w),
    .held         (held_w),
    .erase_run    (erase_run_w),
    .suspend_req  (suspend_req)
  );

  fcd_rdmux #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .MFR_ID(MFR_ID),
    .DEV_ID(DEV_ID)
  ) u_rdmux (
    .mode       (mode_w),
    .rd_addr    (rd_addr),
    .array_rdata(array_rdata),
    .status     (sr_w),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/fcd_checks.sv
module fcd_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_start,
  input logic       erase_start,
  input logic       suspend_req,
  input logic       eng_done,
  input logic       go_write,
  input logic       go_erase,
  input logic       seq_err,
  input logic       clr_err,
  input logic [7:3] sr
);

  a_r13_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && erase_start));

  a_r4_prog_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  a_r5_erase_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start) |-> !sr[7]);

  a_r8_susp_flag_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    sr[6] |-> suspend_req);

  a_r6_bad_confirm_flags: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (sr[5] && sr[4]));

  a_r3_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !eng_done) |=> (sr[5:3] == 3'b000));

  a_r11_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !go_write && !go_erase) |=> sr[7]);

endmodule

bind flash_cmd_decoder fcd_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prog_start (prog_start),
  .erase_start(erase_start),
  .suspend_req(suspend_req),
  .eng_done   (eng_done),
  .go_write   (go_write_w),
  .go_erase   (go_erase_w),
  .seq_err    (seq_err_w),
  .clr_err    (clr_err_w),
  .sr         (sr_w[7:3])
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  localparam int          AW   = 10;
  localparam int          DW   = 16;
  localparam int          BL   = 7;
  localparam logic [15:0] MFR  = 16'h005A;
  localparam logic [15:0] DEV  = 16'h00C3;

  logic clk, rst_n;
  logic wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, array_rdata, rd_data;
  logic eng_done, eng_fail, eng_vlow, eng_suspended;
  logic prog_start, erase_start, suspend_req;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [AW-BL-1:0] erase_blk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done_flag = 0;

  flash_cmd_decoder #(
    .ADDR_W(AW), .DATA_W(DW), .BLK_LSB(BL), .MFR_ID(MFR), .DEV_ID(DEV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data),
    .eng_done(eng_done), .eng_fail(eng_fail), .eng_vlow(eng_vlow),
    .eng_suspended(eng_suspended), .prog_start(prog_start), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_start(erase_start), .erase_blk(erase_blk),
    .suspend_req(suspend_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int m_mode;      // 0 array, 1 signature, 2 status
  int m_pend;      // 0 none, 1 program data due, 2 erase confirm due
  bit m_act, m_ers, m_req, m_park, m_fe, m_fw, m_fv;
  bit m_ps, m_es;
  logic [AW-1:0] m_paddr;
  logic [DW-1:0] m_pdata;
  logic [AW-BL-1:0] m_blk;

  bit t_busy, t_res, t_clr, t_se;
  bit n_act, n_ers, n_req, n_park;
  int n_mode, n_pend;
  logic [7:0] t_cmd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_act = 0; m_ers = 0; m_req = 0; m_park = 0;
      m_fe = 0; m_fw = 0; m_fv = 0; m_ps = 0; m_es = 0;
      m_paddr = '0; m_pdata = '0; m_blk = '0;
    end else begin
      t_cmd = wr_data[7:0];
      t_busy = m_act && !m_park;
      t_res = 0; t_clr = 0; t_se = 0;
      n_act = m_act; n_ers = m_ers; n_req = m_req; n_park = m_park;
      n_mode = m_mode; n_pend = m_pend;
      m_ps = 0; m_es = 0;
      if (wr_en) begin
        if (m_pend == 1) begin
          m_ps = 1; m_paddr = wr_addr; m_pdata = wr_data;
          n_act = 1; n_ers = 0; n_mode = 2; n_pend = 0;
        end else if (m_pend == 2) begin
          if (t_cmd == 8'hD0) begin
            m_es = 1; m_blk = wr_addr[AW-1:BL]; n_act = 1; n_ers = 1;
          end else t_se = 1;
          n_mode = 2; n_pend = 0;
        end else if (t_busy) begin
          if (t_cmd == 8'h70) n_mode = 2;
          else if (t_cmd == 8'hB0 && m_ers) begin n_req = 1; n_mode = 2; end
        end else if (m_park) begin
          case (t_cmd)
            8'hFF: n_mode = 0;
            8'h90: n_mode = 1;
            8'h70: n_mode = 2;
            8'h50: t_clr = 1;
            8'hD0: begin t_res = 1; n_req = 0; n_park = 0; n_mode = 2; end
            default: ;
          endcase
        end else begin
          case (t_cmd)
            8'hFF: n_mode = 0;
            8'h90: n_mode = 1;
            8'h70: n_mode = 2;
            8'h50: t_clr = 1;
            8'h40, 8'h10: n_pend = 1;
            8'h20: n_pend = 2;
            default: ;
          endcase
        end
      end
      if (!t_res && m_req && eng_suspended) n_park = 1;
      if (t_clr) begin m_fe = 0; m_fw = 0; m_fv = 0; end
      if (t_se) begin m_fe = 1; m_fw = 1; end
      if (eng_done && m_act) begin
        n_act = 0; n_req = 0; n_park = 0;
        if (eng_fail) begin if (m_ers) m_fe = 1; else m_fw = 1; end
        if (eng_vlow) m_fv = 1;
      end
      m_act = n_act; m_ers = n_ers; m_req = n_req; m_park = n_park;
      m_mode = n_mode; m_pend = n_pend;
    end
  end

  function automatic logic [7:0] exp_sr();
    return {(!m_act || m_park), m_park, m_fe, m_fw, m_fv, 3'b000};
  endfunction

  function automatic logic [DW-1:0] exp_rd();
    if (m_mode == 1) return (rd_addr == '0) ? MFR : DEV;
    if (m_mode == 2) return {8'h00, exp_sr()};
    return array_rdata;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, between edges
  always @(negedge clk) begin
    #2;
    if (rst_n && !done_flag) begin
      chk("R2 rd_data vs model", rd_data, exp_rd());
      chk("R4 prog_start vs model", prog_start, m_ps);
      chk("R5 erase_start vs model", erase_start, m_es);
      chk("R8 suspend_req vs model", suspend_req, m_req);
      if (m_ps) begin
        chk("R4 prog_addr vs model", prog_addr, m_paddr);
        chk("R4 prog_data vs model", prog_data, m_pdata);
      end
      if (m_es) chk("R5 erase_blk vs model", erase_blk, m_blk);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'h0000;
    #3;
  endtask

  task automatic finish_op(input bit fail, input bit vlow);
    @(negedge clk);
    eng_done = 1'b1; eng_fail = fail; eng_vlow = vlow;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0; eng_vlow = 1'b0;
    #3;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #3;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = 10'h003; array_rdata = 16'h1234;
    eng_done = 0; eng_fail = 0; eng_vlow = 0; eng_suspended = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 array after reset", rd_data, 16'h1234);
    chk("R1 no prog pulse", prog_start, 0);
    chk("R1 no suspend", suspend_req, 0);
    hwrite(10'h000, 16'h0070);
    chk("R1 status after reset", rd_data, 16'h0080);

    // R2 signature and array selection; upper data bits ignored by decode
    hwrite(10'h3FF, 16'hAB90);
    rd_addr = 10'h000; #1;
    chk("R2 manufacturer code", rd_data, MFR);
    rd_addr = 10'h001; #1;
    chk("R2 device code", rd_data, DEV);
    // R12 unknown code leaves signature selection
    hwrite(10'h000, 16'h0033);
    chk("R12 unknown code ignored", rd_data, DEV);
    hwrite(10'h000, 16'h00FF);
    array_rdata = 16'h4321; #1;
    chk("R2 array selected", rd_data, 16'h4321);

    // R4 program via 40h, busy behaviour, R10 suspend ignored on program
    hwrite(10'h000, 16'h0040);
    @(negedge clk); wr_en = 1; wr_addr = 10'h155; wr_data = 16'hBEEF;
    @(negedge clk); wr_en = 0; #2;
    chk("R4 prog pulse", prog_start, 1);
    chk("R4 prog addr", prog_addr, 10'h155);
    chk("R4 prog data", prog_data, 16'hBEEF);
    chk("R7 not ready", rd_data, 16'h0000);
    @(negedge clk); #2;
    chk("R4 pulse is single", prog_start, 0);
    hwrite(10'h000, 16'h00FF);
    chk("R7 busy ignores FF", rd_data, 16'h0000);
    hwrite(10'h000, 16'h00B0);
    chk("R10 suspend ignored during program", suspend_req, 0);
    finish_op(1, 0);
    chk("R11 write fail flag", rd_data, 16'h0090);

    // R3 clear, no second cycle consumed
    hwrite(10'h000, 16'h0050);
    chk("R3 flags cleared", rd_data, 16'h0080);
    hwrite(10'h000, 16'h00FF);
    chk("R3 next write is a new command", rd_data, 16'h4321);

    // R4 alternate opcode, R11 voltage flag
    hwrite(10'h000, 16'h0010);
    hwrite(10'h2AA, 16'h5A5A);
    chk("R4 alternate opcode data", prog_data, 16'h5A5A);
    finish_op(0, 1);
    chk("R11 voltage flag", rd_data, 16'h0088);
    hwrite(10'h000, 16'h0050);

    // R5 erase, R8 suspend, R9 suspended behaviour and resume
    hwrite(10'h000, 16'h0020);
    @(negedge clk); wr_en = 1; wr_addr = 10'h2C5; wr_data = 16'h00D0;
    @(negedge clk); wr_en = 0; #2;
    chk("R5 erase pulse", erase_start, 1);
    chk("R5 erase block", erase_blk, 3'd5);
    hwrite(10'h000, 16'h00B0);
    chk("R8 suspend requested", suspend_req, 1);
    chk("R8 not yet parked", rd_data, 16'h0000);
    eng_suspended = 1;
    idle(2);
    chk("R8 parked status", rd_data, 16'h00C0);
    hwrite(10'h000, 16'h00FF);
    chk("R9 array while parked", rd_data, 16'h4321);
    hwrite(10'h000, 16'h0040);
    hwrite(10'h000, 16'h0070);
    chk("R9 program ignored while parked", rd_data, 16'h00C0);
    hwrite(10'h000, 16'h00D0);
    chk("R9 resume drops request", suspend_req, 0);
    chk("R9 resume status", rd_data, 16'h0000);
    eng_suspended = 0;
    idle(2);
    finish_op(1, 0);
    chk("R11 erase fail flag", rd_data, 16'h00A0);
    hwrite(10'h000, 16'h0050);

    // R6 bad confirm
    hwrite(10'h000, 16'h00FF);
    hwrite(10'h000, 16'h0020);
    hwrite(10'h080, 16'h00FF);
    chk("R6 no erase pulse", erase_start, 0);
    chk("R6 error flags", rd_data, 16'h00B0);
    hwrite(10'h000, 16'h0050);

    // R10 suspend with nothing running
    hwrite(10'h000, 16'h00FF);
    hwrite(10'h000, 16'h00B0);
    chk("R10 idle suspend ignored mode", rd_data, 16'h4321);
    chk("R10 idle suspend no request", suspend_req, 0);

    // R13 both pulses are never seen together in any phase above
    chk("R13 pulses exclusive", {prog_start, erase_start} == 2'b11, 0);

    idle(3);
    done_flag = 1;
    report();
  end

endmodule